// File: doc/BRIEF.md
# I2C Master Clock Phase Timer

This block generates the master-side SCL waveform of an I2C controller from one packed 32-bit timing word. The word sets a prescaler, a data-setup delay, a data-hold delay and the lengths of the SCL high and low phases. While enabled, the block alternates between a driven-low phase and a released phase. During each low phase it raises two single-cycle strobes. The first, `sda_change`, tells the byte engine that SDA may now change. The second, `sda_setup_ok`, tells it that the data has been set up long enough before SCL is released.

The block samples the SCL line and does not count the released phase until the line actually reads high. A slave that holds SCL low therefore stretches the clock. A new timing word is taken only while the block is disabled, so a period cannot change part-way through a transfer. When disabled, the block leaves the line released and resets every counter. Byte sequencing, addressing and acknowledge handling sit outside this block.

Top module: `scl_timing_engine`

## Requirements
- R1: The timing word fields are prescaler P = bits 31:28, setup delay S = bits 23:20, hold delay D = bits 19:16, high count H = bits 15:8 and low count L = bits 7:0. Bits 27:24 have no effect.
- R2: One tick lasts P+1 clock cycles. A low phase (`scl_drive_low` = 1) lasts N ticks, where N = max(L+1, D+S+2).
- R3: With no stretching, a released phase lasts 1 + (H+1)*(P+1) cycles, because the sampled SCL input adds one cycle of latency.
- R4: `sda_change` is a one-cycle pulse in cycle D*(P+1) of every low phase, counting the first low cycle as 0.
- R5: `sda_setup_ok` is a one-cycle pulse in cycle (N-S-1)*(P+1) of every low phase, which is S+1 ticks before SCL is released.
- R6: In every low phase `sda_change` comes strictly before `sda_setup_ok`. The two never fire together and never fire outside a low phase.
- R7: The released-phase count does not advance while the sampled SCL input reads low. Each extra cycle that an external device holds SCL low lengthens the released phase by one cycle.
- R8: The timing word is captured only while `en` is low. Changes made while `en` is high do not affect the running waveform.
- R9: `scl_drive_low` goes to 0 one cycle after `en` is sampled low, and both strobes stay quiet while the block is disabled. After `en` rises, the first low phase begins in the following cycle.
- R10: After reset, `scl_drive_low`, `sda_change` and `sda_setup_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; the timing word is captured while low |
| timing_word | input | 32 | Packed prescaler, setup, hold, high and low fields |
| scl_in | input | 1 | Level seen on the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_change | output | 1 | One-cycle strobe: SDA may change now |
| sda_setup_ok | output | 1 | One-cycle strobe: SDA setup time before release is met |

## Verification
A prescale counter that has drifted shows up as a wrong phase length, or as a strobe offset that is not a multiple of P+1, within the first phase it touches. A wrong tick count or phase state shows up within one period, because every low phase, both strobe offsets and every released phase are measured against values computed from the timing word. Broken stretch handling shows up in the first stretched high phase as a length that is off by the stretch count. A capture that leaks through while enabled appears in the next phase boundary after the word changes.

// File: rtl/scl_tim_pkg.sv
package scl_tim_pkg;
  localparam int WORD_W = 32;
  localparam int PRE_W  = 4;
  localparam int DLY_W  = 4;
  localparam int PH_W   = 8;
  localparam int PRE_LSB = 28;
  localparam int SU_LSB  = 20;
  localparam int HD_LSB  = 16;
  localparam int HI_LSB  = 8;
  localparam int LO_LSB  = 0;
  localparam int TK_W    = PH_W + 1;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [DLY_W-1:0] su;
    logic [DLY_W-1:0] hd;
    logic [PH_W-1:0]  hi;
    logic [PH_W-1:0]  lo;
  } tcfg_t;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

  function automatic tcfg_t unpack_word(input logic [WORD_W-1:0] w);
    tcfg_t c;
    c.pre = w[PRE_LSB +: PRE_W];
    c.su  = w[SU_LSB  +: DLY_W];
    c.hd  = w[HD_LSB  +: DLY_W];
    c.hi  = w[HI_LSB  +: PH_W];
    c.lo  = w[LO_LSB  +: PH_W];
    return c;
  endfunction
endpackage

// File: rtl/timing_cfg_reg.sv
module timing_cfg_reg
  import scl_tim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [WORD_W-1:0] word,
  output tcfg_t             cfg,
  output logic [TK_W-1:0]   last_low,
  output logic [TK_W-1:0]   setup_idx
);
  tcfg_t           cfg_d;
  logic [TK_W-1:0] lo_ext;
  logic [TK_W-1:0] dly_min;

  always_comb begin
    cfg_d = cfg;
    if (!en) cfg_d = unpack_word(word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else        cfg <= cfg_d;
  end

  // last tick index of the low phase, widened so hold strobe precedes setup strobe
  always_comb begin
    lo_ext    = TK_W'(cfg.lo);
    dly_min   = TK_W'(cfg.hd) + TK_W'(cfg.su) + TK_W'(1);
    last_low  = (lo_ext > dly_min) ? lo_ext : dly_min;
    setup_idx = last_low - TK_W'(cfg.su);
  end

  // R8: the captured word is frozen while enabled
  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(cfg));
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
  import scl_tim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick_last,
  output logic             tick_first
);
  logic [PRE_W-1:0] pcnt, pcnt_d;

  always_comb begin
    tick_last  = (pcnt == pre);
    tick_first = (pcnt == '0);
    pcnt_d     = pcnt;
    if (clr)      pcnt_d = '0;
    else if (run) pcnt_d = tick_last ? '0 : pcnt + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt_d;
  end

  // R2: the prescale counter never passes the programmed limit
  a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= pre);
endmodule

// File: rtl/scl_phase_ctl.sv
module scl_phase_ctl
  import scl_tim_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            scl_in,
  input  tcfg_t           cfg,
  input  logic [TK_W-1:0] last_low,
  input  logic [TK_W-1:0] setup_idx,
  input  logic            tick_last,
  input  logic            tick_first,
  output logic            run,
  output logic            clr,
  output logic            scl_drive_low,
  output logic            sda_change,
  output logic            sda_setup_ok
);
  phase_t          state, state_d;
  logic [TK_W-1:0] tcnt, tcnt_d;
  logic            scl_q;
  logic            chg_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b0;
    else        scl_q <= scl_in;
  end

  always_comb begin
    run = (state == PH_LOW) || ((state == PH_HIGH) && scl_q);
    clr = (state == PH_IDLE);
  end

  always_comb begin
    state_d = state;
    tcnt_d  = tcnt;
    if (!en) begin
      state_d = PH_IDLE;
      tcnt_d  = '0;
    end else begin
      case (state)
        PH_IDLE: begin
          state_d = PH_LOW;
          tcnt_d  = '0;
        end
        PH_LOW: if (tick_last) begin
          if (tcnt == last_low) begin
            state_d = PH_HIGH;
            tcnt_d  = '0;
          end else begin
            tcnt_d = tcnt + TK_W'(1);
          end
        end
        PH_HIGH: if (run && tick_last) begin
          if (tcnt == TK_W'(cfg.hi)) begin
            state_d = PH_LOW;
            tcnt_d  = '0;
          end else begin
            tcnt_d = tcnt + TK_W'(1);
          end
        end
        default: begin
          state_d = PH_IDLE;
          tcnt_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      tcnt  <= '0;
    end else begin
      state <= state_d;
      tcnt  <= tcnt_d;
    end
  end

  always_comb begin
    scl_drive_low = (state == PH_LOW);
    sda_change    = (state == PH_LOW) && tick_first && (tcnt == TK_W'(cfg.hd));
    sda_setup_ok  = (state == PH_LOW) && tick_first && (tcnt == setup_idx);
  end

  // tracks the hold strobe within the current low phase, for the order check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  chg_seen <= 1'b0;
    else if (state != PH_LOW)    chg_seen <= 1'b0;
    else if (sda_change)         chg_seen <= 1'b1;
  end

  // R6: setup strobe only after the hold strobe of the same low phase
  a_r6_order: assert property (@(posedge clk) disable iff (!rst_n)
    sda_setup_ok |-> chg_seen);
  // R6: strobes never coincide
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sda_change, sda_setup_ok}));
  // R4: hold strobe only while SCL is driven low
  a_r4_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change |-> scl_drive_low);
  // R7: released-phase tick count holds while the line reads low
  a_r7_stretch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == PH_HIGH && !scl_q) |=> $stable(tcnt));
  // R9: disabling releases the line on the next cycle
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !scl_drive_low);
endmodule

// File: rtl/scl_timing_engine.sv
module scl_timing_engine
  import scl_tim_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [31:0] timing_word,
  input  logic        scl_in,
  output logic        scl_drive_low,
  output logic        sda_change,
  output logic        sda_setup_ok
);
  tcfg_t           cfg;
  logic [TK_W-1:0] last_low;
  logic [TK_W-1:0] setup_idx;
  logic            tick_last, tick_first, run, clr;

  timing_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .word      (timing_word),
    .cfg       (cfg),
    .last_low  (last_low),
    .setup_idx (setup_idx)
  );

  scl_tick_gen u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .run        (run),
    .pre        (cfg.pre),
    .tick_last  (tick_last),
    .tick_first (tick_first)
  );

  scl_phase_ctl u_phase (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .scl_in        (scl_in),
    .cfg           (cfg),
    .last_low      (last_low),
    .setup_idx     (setup_idx),
    .tick_last     (tick_last),
    .tick_first    (tick_first),
    .run           (run),
    .clr           (clr),
    .scl_drive_low (scl_drive_low),
    .sda_change    (sda_change),
    .sda_setup_ok  (sda_setup_ok)
  );
endmodule

// File: tb/sim_scl_timing_engine.sv
module sim_scl_timing_engine;
  typedef struct {
    int low_len;
    int chg_off;
    int su_off;
    int high_len;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [31:0] timing_word;
  logic        stretch;
  logic        scl_in;
  logic        scl_drive_low, sda_change, sda_setup_ok;

  int   n_tests = 0;
  int   n_fail  = 0;
  int   done_cnt = 0;
  int   stretch_len = 0;
  exp_t expq[$];

  assign scl_in = !scl_drive_low && !stretch;

  scl_timing_engine u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .timing_word   (timing_word),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .sda_change    (sda_change),
    .sda_setup_ok  (sda_setup_ok)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] w, input int s_extra);
    exp_t e;
    int p, su, hd, hi, lo, n;
    p  = int'(w[31:28]);
    su = int'(w[23:20]);
    hd = int'(w[19:16]);
    hi = int'(w[15:8]);
    lo = int'(w[7:0]);
    n  = (lo + 1 > hd + su + 2) ? lo + 1 : hd + su + 2;
    e.low_len  = n * (p + 1);
    e.chg_off  = hd * (p + 1);
    e.su_off   = (n - su - 1) * (p + 1);
    e.high_len = 1 + (hi + 1) * (p + 1) + s_extra;
    return e;
  endfunction

  // monitor: measures each period and compares against the queue
  int  lc, hc, chg, su, low_len, scnt;
  bit  prev_drv, have_low;
  initial begin
    stretch = 1'b0;
    prev_drv = 1'b0; have_low = 1'b0;
    lc = 0; hc = 0; chg = -1; su = -1; low_len = 0; scnt = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || !en) begin
        have_low = 1'b0; lc = 0; hc = 0; scnt = 0;
        stretch <= 1'b0;
        if (rst_n) begin
          check(!sda_change && !sda_setup_ok, "R9 quiet strobes", int'(sda_change) + int'(sda_setup_ok), 0);
        end
      end else if (scl_drive_low) begin
        if (!prev_drv) begin
          if (have_low) begin
            if (expq.size() == 0) begin
              check(1'b0, "R2 unexpected period", 1, 0);
            end else begin
              exp_t e;
              e = expq.pop_front();
              check(low_len == e.low_len, "R2 low length", low_len, e.low_len);
              check(chg == e.chg_off, "R4 sda_change offset", chg, e.chg_off);
              check(su == e.su_off, "R5 sda_setup_ok offset", su, e.su_off);
              check(hc == e.high_len, "R3/R7 high length", hc, e.high_len);
              check(chg < su, "R6 strobe order", chg, su);
            end
            done_cnt++;
          end
          lc = 0; chg = -1; su = -1;
        end
        if (sda_change)   chg = lc;
        if (sda_setup_ok) su  = lc;
        lc++;
      end else begin
        if (prev_drv) begin
          low_len = lc;
          have_low = 1'b1;
          hc = 0;
          if (stretch_len > 0) begin
            stretch <= 1'b1;
            scnt = stretch_len;
          end
        end else if (scnt > 0) begin
          scnt--;
          if (scnt == 0) stretch <= 1'b0;
        end
        if (sda_change || sda_setup_ok) check(1'b0, "R6 strobe outside low", 1, 0);
        hc++;
      end
      prev_drv = scl_drive_low && en && rst_n;
    end
  end

  task automatic run_cfg(input logic [31:0] w, input int periods, input int s_extra,
                         input bit change_mid, input logic [31:0] w_alt);
    exp_t e;
    int   target;
    @(negedge clk);
    en <= 1'b0;
    timing_word <= w;
    stretch_len = s_extra;
    repeat (3) @(negedge clk);
    e = model(w, s_extra);
    for (int i = 0; i < periods; i++) expq.push_back(e);
    target = done_cnt + periods;
    en <= 1'b1;
    @(negedge clk);
    check(scl_drive_low == 1'b1, "R9 low phase starts after enable", int'(scl_drive_low), 1);
    if (change_mid) timing_word <= w_alt; // R8: must have no effect
    while (done_cnt < target) @(negedge clk);
    en <= 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(scl_drive_low == 1'b0, "R9 released after disable", int'(scl_drive_low), 0);
    check(expq.size() == 0, "R2 leftover expectations", expq.size(), 0);
    expq.delete();
  endtask

  initial begin
    rst_n = 1'b0;
    en = 1'b0;
    timing_word = 32'h0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(scl_drive_low == 1'b0, "R10 drive after reset", int'(scl_drive_low), 0);
    check(!sda_change && !sda_setup_ok, "R10 strobes after reset", int'(sda_change) + int'(sda_setup_ok), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 R3 R4 R5: basic word, no prescale
    run_cfg({4'h0, 4'h0, 4'h1, 4'h1, 8'd3, 8'd5}, 3, 0, 1'b0, 32'h0);
    // R1: bits 27:24 set, prescale by 3
    run_cfg({4'h2, 4'hF, 4'h2, 4'h0, 8'd2, 8'd9}, 3, 0, 1'b0, 32'h0);
    // R6: hold + setup exceed low count, low phase extended
    run_cfg({4'h1, 4'h0, 4'h5, 4'h6, 8'd1, 8'd2}, 2, 0, 1'b0, 32'h0);
    // R6: extreme delays with zero low and high counts
    run_cfg({4'h0, 4'h0, 4'hF, 4'hF, 8'd0, 8'd0}, 2, 0, 1'b0, 32'h0);
    // R7: clock stretched by five cycles each period
    run_cfg({4'h1, 4'h0, 4'h0, 4'h0, 8'd2, 8'd3}, 3, 5, 1'b0, 32'h0);
    // R8: word changed while enabled is ignored
    run_cfg({4'h0, 4'h0, 4'h1, 4'h1, 8'd3, 8'd5}, 3, 0, 1'b1, {4'h3, 4'h0, 4'h4, 4'h2, 8'd9, 8'd12});
    // R2: largest counts with maximum prescale
    run_cfg({4'hF, 4'h0, 4'h3, 4'h2, 8'd255, 8'd255}, 2, 0, 1'b0, 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule